// File: doc/BRIEF.md
# Cascadable Quadrature Phase Counter

This block turns a two-phase encoder signal into a signed-direction position count. A lower 16-bit channel watches its own pair of phase inputs, brings them into the clock domain, and counts every edge of either phase (4x decoding). When phase A leads the count rises, and when phase B leads it falls. It wraps at both ends and emits a one-cycle pulse for each wrap.

An upper 16-bit channel is chosen by a two-bit mode. It can hold its value, decode its own pair of phase inputs, or take the lower channel's wrap pulses as its count input. In that last case the two channels together form one 32-bit position that moves in a single clock edge. Each channel has a direction flag that shows which way its last count went.

Top module: `quad_cascade_counter`

## Requirements
- R1: After reset, `cnt_o` is 0, both direction flags are 0 and all four wrap pulses are 0.
- R2: With `lo_en_i` high, a change of exactly one lower phase input moves the low half of `cnt_o` by one. It counts up when the new phase A level differs from the old phase B level, and down otherwise. Phase A leading (AB = 00,10,11,01) counts up. The count appears at the third rising clock edge after the input change.
- R3: If both phase inputs of a channel change within the same sampled cycle, that channel does not count.
- R4: While `lo_en_i` is low, the low half of `cnt_o` and `lo_dir_o` hold their values whatever the lower phases do.
- R5: The low half wraps from 0xFFFF to 0x0000 with `lo_ovf_o` high for one cycle, and from 0x0000 to 0xFFFF with `lo_unf_o` high for one cycle. Each pulse is high in the same cycle as the wrapped value.
- R6: A direction flag is 0 after an up count and 1 after a down count. It changes only when its channel counts.
- R7: `hi_mode_i` selects the upper channel's source: 2'b00 and 2'b11 hold, 2'b01 decodes the upper phase inputs by the rule of R2 and R3, and 2'b10 is cascade.
- R8: In cascade mode, a lower wrap up adds one to the high half of `cnt_o` on the same edge as the wrap, and a lower wrap down subtracts one. No other event moves the high half, so `cnt_o` reads as one 32-bit count.
- R9: The high half wraps with one-cycle `hi_ovf_o` (0xFFFF to 0x0000) and `hi_unf_o` (0x0000 to 0xFFFF) pulses, each in the same cycle as the wrapped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lo_a_i | input | 1 | Lower channel phase A, asynchronous |
| lo_b_i | input | 1 | Lower channel phase B, asynchronous |
| hi_a_i | input | 1 | Upper channel phase A, asynchronous |
| hi_b_i | input | 1 | Upper channel phase B, asynchronous |
| lo_en_i | input | 1 | Lower channel phase counting enable |
| hi_mode_i | input | 2 | Upper channel source: 00 hold, 01 own phases, 10 cascade, 11 hold |
| cnt_o | output | 32 | {upper count, lower count} |
| lo_dir_o | output | 1 | Lower direction of last count, 1 = down |
| hi_dir_o | output | 1 | Upper direction of last count, 1 = down |
| lo_ovf_o | output | 1 | Lower wrap-up pulse |
| lo_unf_o | output | 1 | Lower wrap-down pulse |
| hi_ovf_o | output | 1 | Upper wrap-up pulse |
| hi_unf_o | output | 1 | Upper wrap-down pulse |

## Verification
The decoder is driven with several patterns, each of which exposes a different kind of fault:

- A forward Gray walk and a reverse walk show whether the direction is decoded correctly at each of the four transitions.
- A simultaneous change of both phases separates valid steps from invalid ones.
- Steps taken while disabled, or in a hold mode, show any leak into a counter that should stand still.
- Single steps across each wrap point, in both directions, check the pulse timing against the wrapped value and check that the high half moves on the same edge in cascade.
- A long run of one change per cycle over a full lower period confirms that back-to-back edges are all counted and carried.

// File: rtl/quad_cascade_counter.sv
module quad_cascade_counter #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           lo_a_i,
  input  logic           lo_b_i,
  input  logic           hi_a_i,
  input  logic           hi_b_i,
  input  logic           lo_en_i,
  input  logic [1:0]     hi_mode_i,
  output logic [2*W-1:0] cnt_o,
  output logic           lo_dir_o,
  output logic           hi_dir_o,
  output logic           lo_ovf_o,
  output logic           lo_unf_o,
  output logic           hi_ovf_o,
  output logic           hi_unf_o
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] ONE = W'(1);

  logic [2:0] la_s, lb_s, ha_s, hb_s;
  logic [W-1:0] lo_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      la_s <= '0; lb_s <= '0; ha_s <= '0; hb_s <= '0;
    end else begin
      la_s <= {la_s[1:0], lo_a_i};
      lb_s <= {lb_s[1:0], lo_b_i};
      ha_s <= {ha_s[1:0], hi_a_i};
      hb_s <= {hb_s[1:0], hi_b_i};
    end
  end

  // one phase moved -> valid; direction from new A against old B
  logic lo_valid, lo_up, hq_valid, hq_up;
  assign lo_valid = (la_s[1] ^ la_s[2]) ^ (lb_s[1] ^ lb_s[2]);
  assign lo_up    = la_s[1] ^ lb_s[2];
  assign hq_valid = (ha_s[1] ^ ha_s[2]) ^ (hb_s[1] ^ hb_s[2]);
  assign hq_up    = ha_s[1] ^ hb_s[2];

  logic lo_step, lo_wup, lo_wdn;
  assign lo_step = lo_en_i & lo_valid;
  assign lo_wup  = lo_step &  lo_up & (lo_q == TOP);
  assign lo_wdn  = lo_step & ~lo_up & (lo_q == '0);

  logic hi_step, hi_up;
  always_comb begin
    hi_step = 1'b0;
    hi_up   = 1'b0;
    unique case (hi_mode_i)
      2'b01: begin hi_step = hq_valid;        hi_up = hq_up;  end
      2'b10: begin hi_step = lo_wup | lo_wdn; hi_up = lo_wup; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0; hi_q <= '0;
      lo_dir_o <= 1'b0; hi_dir_o <= 1'b0;
      lo_ovf_o <= 1'b0; lo_unf_o <= 1'b0;
      hi_ovf_o <= 1'b0; hi_unf_o <= 1'b0;
    end else begin
      lo_ovf_o <= lo_wup;
      lo_unf_o <= lo_wdn;
      hi_ovf_o <= hi_step &  hi_up & (hi_q == TOP);
      hi_unf_o <= hi_step & ~hi_up & (hi_q == '0);
      if (lo_step) begin
        lo_q     <= lo_up ? lo_q + ONE : lo_q - ONE;
        lo_dir_o <= ~lo_up;
      end
      if (hi_step) begin
        hi_q     <= hi_up ? hi_q + ONE : hi_q - ONE;
        hi_dir_o <= ~hi_up;
      end
    end
  end

  assign cnt_o = {hi_q, lo_q};
endmodule

// File: rtl/quad_cascade_counter_chk.sv
module quad_cascade_counter_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           lo_en_i,
  input logic [1:0]     hi_mode_i,
  input logic [2*W-1:0] cnt_o,
  input logic           lo_ovf_o,
  input logic           lo_unf_o,
  input logic           hi_ovf_o,
  input logic           hi_unf_o
);
  logic [W-1:0] lo, hi;
  assign lo = cnt_o[W-1:0];
  assign hi = cnt_o[2*W-1:W];

  // R2
  lo_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo == $past(lo)) || (lo == W'($past(lo) + 1)) || (lo == W'($past(lo) - 1)));

  // R4
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(lo_en_i) |-> $stable(lo));

  // R5
  lo_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_ovf_o |-> (lo == '0) && ($past(lo) == '1));

  // R5
  lo_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_unf_o |-> (lo == '1) && ($past(lo) == '0));

  // R5
  lo_pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_ovf_o && lo_unf_o));

  // R8
  cascade_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hi_mode_i) == 2'b10 && lo_ovf_o) |-> hi == W'($past(hi) + 1));

  // R8
  cascade_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hi_mode_i) == 2'b10 && lo_unf_o) |-> hi == W'($past(hi) - 1));

  // R8
  cascade_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hi_mode_i) == 2'b10 && !lo_ovf_o && !lo_unf_o) |-> $stable(hi));

  // R7
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hi_mode_i) == 2'b00 || $past(hi_mode_i) == 2'b11) |-> $stable(hi));

  // R9
  hi_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_ovf_o |-> (hi == '0) && ($past(hi) == '1));

  // R9
  hi_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_unf_o |-> (hi == '1) && ($past(hi) == '0));
endmodule

bind quad_cascade_counter quad_cascade_counter_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .lo_en_i(lo_en_i), .hi_mode_i(hi_mode_i),
  .cnt_o(cnt_o), .lo_ovf_o(lo_ovf_o), .lo_unf_o(lo_unf_o),
  .hi_ovf_o(hi_ovf_o), .hi_unf_o(hi_unf_o)
);

// File: tb/quad_cascade_counter_test.sv
`timescale 1ns/1ps
module quad_cascade_counter_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lo_a = 0, lo_b = 0, hi_a = 0, hi_b = 0, lo_en = 0;
  logic [1:0] hi_mode = 2'b00;
  logic [31:0] cnt;
  logic lo_dir, hi_dir, lo_ovf, lo_unf, hi_ovf, hi_unf;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] exp_lo = 0, exp_hi = 0;
  logic exp_lo_dir = 0, exp_hi_dir = 0;

  always #2.5 clk = ~clk;

  quad_cascade_counter uut (
    .clk(clk), .rst_n(rst_n), .lo_a_i(lo_a), .lo_b_i(lo_b),
    .hi_a_i(hi_a), .hi_b_i(hi_b), .lo_en_i(lo_en), .hi_mode_i(hi_mode),
    .cnt_o(cnt), .lo_dir_o(lo_dir), .hi_dir_o(hi_dir),
    .lo_ovf_o(lo_ovf), .lo_unf_o(lo_unf), .hi_ovf_o(hi_ovf), .hi_unf_o(hi_unf)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  // Gray walk: up is 00->10->11->01->00 on (A,B)
  task automatic move(inout logic a, inout logic b, input bit up);
    if (up) begin if (a == b) a = ~a; else b = ~b; end
    else    begin if (a == b) b = ~b; else a = ~a; end
  endtask

  task automatic model_lo(input bit up, output bit lw_up, output bit lw_dn, output bit hw_up, output bit hw_dn);
    lw_up = 0; lw_dn = 0; hw_up = 0; hw_dn = 0;
    if (!lo_en) return;
    exp_lo_dir = !up;
    if (up) begin lw_up = (exp_lo == 16'hFFFF); exp_lo = exp_lo + 1; end
    else    begin lw_dn = (exp_lo == 16'h0000); exp_lo = exp_lo - 1; end
    if (hi_mode == 2'b10 && (lw_up || lw_dn)) begin
      exp_hi_dir = lw_dn;
      if (lw_up) begin hw_up = (exp_hi == 16'hFFFF); exp_hi = exp_hi + 1; end
      else       begin hw_dn = (exp_hi == 16'h0000); exp_hi = exp_hi - 1; end
    end
  endtask

  task automatic check_state(input string req);
    chk_eq({req, " lo count"}, {16'h0, cnt[15:0]}, {16'h0, exp_lo});
    chk_eq({req, " hi count"}, {16'h0, cnt[31:16]}, {16'h0, exp_hi});
    chk_eq({req, " lo dir"}, {31'h0, lo_dir}, {31'h0, exp_lo_dir});
    chk_eq({req, " hi dir"}, {31'h0, hi_dir}, {31'h0, exp_hi_dir});
  endtask

  task automatic lo_step_chk(input bit up, input string req);
    bit lu, ld, hu, hd;
    move(lo_a, lo_b, up);
    model_lo(up, lu, ld, hu, hd);
    repeat (3) @(negedge clk);
    check_state(req);
    chk_eq({req, " lo_ovf"}, {31'h0, lo_ovf}, {31'h0, lu});
    chk_eq({req, " lo_unf"}, {31'h0, lo_unf}, {31'h0, ld});
    chk_eq({req, " hi_ovf"}, {31'h0, hi_ovf}, {31'h0, hu});
    chk_eq({req, " hi_unf"}, {31'h0, hi_unf}, {31'h0, hd});
  endtask

  task automatic test_reset;
    chk_eq("R1 count", cnt, 32'h0);
    chk_eq("R1 pulses", {28'h0, lo_ovf, lo_unf, hi_ovf, hi_unf}, 32'h0);
    chk_eq("R1 dirs", {30'h0, lo_dir, hi_dir}, 32'h0);
  endtask

  task automatic test_forward_reverse;
    lo_en = 1; hi_mode = 2'b00;
    for (int i = 0; i < 4; i++) lo_step_chk(1, "R2 R6 up");
    for (int i = 0; i < 6; i++) lo_step_chk(0, "R2 R5 R6 R7 down");
  endtask

  task automatic test_invalid;
    lo_a = ~lo_a; lo_b = ~lo_b;
    repeat (3) @(negedge clk);
    check_state("R3 both phases");
  endtask

  task automatic test_disabled;
    lo_en = 0;
    for (int i = 0; i < 3; i++) begin
      move(lo_a, lo_b, 1);
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check_state("R4 disabled");
    lo_en = 1;
  endtask

  task automatic test_cascade_wraps;
    hi_mode = 2'b11;
    lo_step_chk(1, "R7 mode11");
    lo_step_chk(1, "R5 R7 mode11 wrap");
    hi_mode = 2'b10;
    lo_step_chk(0, "R8 R9 borrow");
    lo_step_chk(1, "R8 R9 carry");
  endtask

  task automatic test_bulk;
    bit lu, ld, hu, hd;
    for (int i = 0; i < 65536; i++) begin
      move(lo_a, lo_b, 1);
      model_lo(1, lu, ld, hu, hd);
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check_state("R2 R8 full period");
  endtask

  task automatic hi_step_chk(input bit up, input string req);
    move(hi_a, hi_b, up);
    exp_hi = up ? exp_hi + 1 : exp_hi - 1;
    exp_hi_dir = !up;
    repeat (3) @(negedge clk);
    check_state(req);
  endtask

  task automatic test_hi_own;
    hi_mode = 2'b01;
    hi_step_chk(1, "R7 own up");
    hi_step_chk(1, "R7 own up");
    hi_step_chk(0, "R6 R7 own down");
    hi_a = ~hi_a; hi_b = ~hi_b;
    repeat (3) @(negedge clk);
    check_state("R3 R7 hi both phases");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset;
    rst_n = 1;
    repeat (2) @(negedge clk);
    test_reset;
    test_forward_reverse;
    test_invalid;
    test_disabled;
    test_cascade_wraps;
    test_bulk;
    test_hi_own;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule